// File: doc/BRIEF.md
# Recycling Delay-Line Time-to-Digital Converter Controller

This block holds the digital side of a two-level time-to-digital converter. A short delay line is fed one reference-clock edge, and that edge is then looped back through the line many times before a fresh edge is admitted. The block runs on the internal round clock, where one clock period equals one trip of the edge around the line. It drives the loop-back multiplexer select. It keeps a free-running round counter and counts the full reference periods that elapse between a start pulse and a stop pulse.

Each timing pulse captures two vectors. The first is the sampled tap vector of the delay line, which is a thermometer code. The second is an 8-bit coincidence vector from the capacitor-scaled fine cells. The block turns each pulse into one absolute position code, measured in fine steps. When the stop pulse arrives it outputs the difference between the stop and start positions as a binary interval code, together with a one-cycle valid pulse. A measurement that runs past the range of the cycle counter is flagged as an overflow, and no code is produced for it.

The control is a four-state machine.
- ARMED waits for start. It goes to MEASURE on start.
- MEASURE counts reference periods. It goes to REPORT on stop, or to OVERRUN when the cycle counter would pass its maximum.
- REPORT presents the result for one cycle and always returns to ARMED.
- OVERRUN waits for stop and then returns to ARMED.

A synchronous reset forces ARMED from any state.

Top module: `rdtdc_ctrl`

## Requirements
- R1: The round counter steps 0,1,…,N-1 and then wraps to 0 on every clock, free-running after reset. `inject_o` is high exactly while the counter holds N-1, which is one cycle in every N. In that cycle the next trip uses a fresh reference edge.
- R2: A start pulse is accepted only in ARMED. After it is accepted, `busy_o` is high from the next cycle. A stop pulse is acted on only in MEASURE. A stop outside MEASURE and a second start during MEASURE have no effect on any output.
- R3: The reference-cycle count is cleared on an accepted start. It increases by one at every clock edge in MEASURE where the round counter is N-1, and this includes the start edge itself. Together with the round value, it gives the elapsed position `cycles*N + round`.
- R4: The tap vector is decoded with bit 0 as the first tap. The index is the lowest i for which tap i and tap i+1 are both 0, with a virtual tap TAPS taken as 0. If no such i exists the index is TAPS-1. An isolated 0 or 1 bubble therefore does not move the index.
- R5: The fine index is the position of the lowest set bit of the coincidence vector, or 0 if the vector is empty. A vector with no bit set, or with more than one bit set, is an error.
- R6: For each pulse, a position is formed as `((c*N + r)*TAPS + t)*8 + f`. Here c is the cycle count (0 for start), r is the round, t is the tap index and f is the fine index, all taken at the pulse edge. `result_o` equals the stop position minus the start position. `result_valid_o` is high for exactly the one cycle that follows the stop edge.
- R7: Suppose the round counter is N-1 in MEASURE, the cycle count is at its maximum 2^CYC_W-1, and no stop is present. Then `overflow_o` rises and `busy_o` falls, and the stop that follows produces no result. A stop in that same last cycle still reports normally. `overflow_o` stays high until the next accepted start.
- R8: A synchronous reset clears the round counter, `busy_o`, `result_valid_o` and `overflow_o`, and leaves the block in ARMED.
- R9: `fine_err_o` is high together with `result_valid_o` when either the start or the stop fine vector was in error. It is low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal round clock (one recycling trip per period) |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start timing pulse, one cycle |
| stop_i | input | 1 | Stop timing pulse, one cycle |
| taps_i | input | TAPS | Delay-line tap states sampled by the current pulse |
| fine_i | input | FW | Fine coincidence vector sampled by the current pulse |
| inject_o | output | 1 | Multiplexer select: 1 admits a fresh reference edge |
| busy_o | output | 1 | Measurement in progress |
| result_valid_o | output | 1 | One-cycle strobe for `result_o` |
| result_o | output | RES_W | Interval in fine steps |
| fine_err_o | output | 1 | A fine vector of this result was empty or multi-hot |
| overflow_o | output | 1 | Last measurement ran past the cycle counter range |

## Verification
The assertions check the following on every cycle: the round counter steps and wraps in the right way, the cycle count rises only on a wrap, every stop in MEASURE produces exactly one single-cycle strobe, a stop outside MEASURE produces nothing, and overflow never appears together with busy or valid. Only the bench's scenarios can show the arithmetic of the interval code and the thermometer bubble handling. They also cover a start that lands on the wrap cycle, a stop exactly at the last representable position, and the full overflow sequence with a later recovery.

// File: rtl/rdtdc_pkg.sv
package rdtdc_pkg;

    typedef enum logic [1:0] {
        ST_ARMED   = 2'd0,
        ST_MEASURE = 2'd1,
        ST_REPORT  = 2'd2,
        ST_OVERRUN = 2'd3
    } tdc_state_e;

endpackage

// File: rtl/rdtdc_round_ctr.sv
module rdtdc_round_ctr #(
    parameter  int N  = 40,
    localparam int RW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [RW-1:0] round_o,
    output logic          last_o
);

    localparam logic [RW-1:0] LAST = RW'(N - 1);

    always_ff @(posedge clk) begin
        if (rst)
            round_o <= '0;
        else if (round_o == LAST)
            round_o <= '0;
        else
            round_o <= round_o + 1'b1;
    end

    assign last_o = (round_o == LAST);

    AST_ROUND_WRAP: assert property (@(posedge clk) disable iff (rst)
        last_o |=> (round_o == '0)); // R1
    AST_ROUND_STEP: assert property (@(posedge clk) disable iff (rst)
        !last_o |=> (round_o == RW'($past(round_o) + 1'b1))); // R1

endmodule

// File: rtl/rdtdc_therm_dec.sv
module rdtdc_therm_dec #(
    parameter  int TAPS = 8,
    localparam int TW   = $clog2(TAPS)
) (
    input  logic [TAPS-1:0] taps_i,
    output logic [TW-1:0]   idx_o
);

    logic [TAPS:0]   ext;
    logic [TAPS-1:0] hit;

    assign ext = {1'b0, taps_i};

    // a position is an edge only where two adjacent taps are both low
    for (genvar g = 0; g < TAPS; g++) begin : g_hit
        assign hit[g] = ~ext[g] & ~ext[g+1];
    end

    always_comb begin
        idx_o = TW'(TAPS - 1);
        for (int i = TAPS - 1; i >= 0; i--) begin
            if (hit[i])
                idx_o = TW'(i);
        end
    end

endmodule

// File: rtl/rdtdc_fine_enc.sv
module rdtdc_fine_enc #(
    parameter  int FW = 8,
    localparam int IW = $clog2(FW)
) (
    input  logic [FW-1:0] vec_i,
    output logic [IW-1:0] idx_o,
    output logic          err_o
);

    always_comb begin
        idx_o = '0;
        for (int i = FW - 1; i >= 0; i--) begin
            if (vec_i[i])
                idx_o = IW'(i);
        end
    end

    assign err_o = ($countones(vec_i) != 1);

    always_comb begin
        if (!err_o) begin
            AST_FINE_HIT: assert (vec_i[idx_o]); // R5
        end
    end

endmodule

// File: rtl/rdtdc_ctrl.sv
module rdtdc_ctrl
    import rdtdc_pkg::*;
#(
    parameter  int N     = 40,
    parameter  int TAPS  = 8,
    parameter  int FW    = 8,
    parameter  int CYC_W = 13,
    localparam int RW    = $clog2(N),
    localparam int TW    = $clog2(TAPS),
    localparam int IW    = $clog2(FW),
    localparam int RES_W = $clog2((2 ** CYC_W) * N * TAPS * FW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [TAPS-1:0]  taps_i,
    input  logic [FW-1:0]    fine_i,
    output logic             inject_o,
    output logic             busy_o,
    output logic             result_valid_o,
    output logic [RES_W-1:0] result_o,
    output logic             fine_err_o,
    output logic             overflow_o
);

    localparam logic [CYC_W-1:0] CYC_MAX = '1;
    localparam logic [RES_W-1:0] N_R     = RES_W'(N);
    localparam logic [RES_W-1:0] TAPS_R  = RES_W'(TAPS);
    localparam logic [RES_W-1:0] FW_R    = RES_W'(FW);

    tdc_state_e state_q, state_d;

    logic [RW-1:0]    round;
    logic             last;
    logic [TW-1:0]    tap_idx;
    logic [IW-1:0]    fine_idx;
    logic             fine_bad;

    logic [CYC_W-1:0] cyc_q;
    logic [RW-1:0]    s_rnd_q,  e_rnd_q;
    logic [CYC_W-1:0] e_cyc_q;
    logic [TW-1:0]    s_tap_q,  e_tap_q;
    logic [IW-1:0]    s_fine_q, e_fine_q;
    logic             s_err_q,  e_err_q;
    logic             ovf_q;

    rdtdc_round_ctr #(.N(N)) u_round (
        .clk     (clk),
        .rst     (rst),
        .round_o (round),
        .last_o  (last)
    );

    rdtdc_therm_dec #(.TAPS(TAPS)) u_therm (
        .taps_i (taps_i),
        .idx_o  (tap_idx)
    );

    rdtdc_fine_enc #(.FW(FW)) u_fine (
        .vec_i (fine_i),
        .idx_o (fine_idx),
        .err_o (fine_bad)
    );

    function automatic logic [RES_W-1:0] pos_code(
        input logic [CYC_W-1:0] c,
        input logic [RW-1:0]    r,
        input logic [TW-1:0]    t,
        input logic [IW-1:0]    f
    );
        return ((RES_W'(c) * N_R + RES_W'(r)) * TAPS_R + RES_W'(t)) * FW_R + RES_W'(f);
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_ARMED;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED:   if (start_i) state_d = ST_MEASURE;
            ST_MEASURE: begin
                if (stop_i)
                    state_d = ST_REPORT;
                else if (last && (cyc_q == CYC_MAX))
                    state_d = ST_OVERRUN;
            end
            ST_REPORT:  state_d = ST_ARMED;
            ST_OVERRUN: if (stop_i) state_d = ST_ARMED;
            default:    state_d = ST_ARMED;
        endcase
    end

    // capture and counting datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q    <= '0;
            s_rnd_q  <= '0;
            s_tap_q  <= '0;
            s_fine_q <= '0;
            s_err_q  <= 1'b0;
            e_cyc_q  <= '0;
            e_rnd_q  <= '0;
            e_tap_q  <= '0;
            e_fine_q <= '0;
            e_err_q  <= 1'b0;
            ovf_q    <= 1'b0;
        end else begin
            if ((state_q == ST_ARMED) && start_i) begin
                s_rnd_q  <= round;
                s_tap_q  <= tap_idx;
                s_fine_q <= fine_idx;
                s_err_q  <= fine_bad;
                cyc_q    <= last ? CYC_W'(1) : '0;
                ovf_q    <= 1'b0;
            end
            if (state_q == ST_MEASURE) begin
                if (stop_i) begin
                    e_cyc_q  <= cyc_q;
                    e_rnd_q  <= round;
                    e_tap_q  <= tap_idx;
                    e_fine_q <= fine_idx;
                    e_err_q  <= fine_bad;
                end else if (last) begin
                    if (cyc_q == CYC_MAX)
                        ovf_q <= 1'b1;
                    else
                        cyc_q <= cyc_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        inject_o       = last;
        busy_o         = (state_q == ST_MEASURE);
        result_valid_o = (state_q == ST_REPORT);
        fine_err_o     = (state_q == ST_REPORT) && (s_err_q || e_err_q);
        overflow_o     = ovf_q;
        result_o       = pos_code(e_cyc_q, e_rnd_q, e_tap_q, e_fine_q)
                       - pos_code('0, s_rnd_q, s_tap_q, s_fine_q);
    end

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !result_valid_o && !overflow_o && start_i && (state_q == ST_ARMED)) |=> busy_o); // R2
    AST_IDLE_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && stop_i) |=> !result_valid_o); // R2
    AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !stop_i && inject_o && (cyc_q != CYC_MAX)) |=> (cyc_q == CYC_W'($past(cyc_q) + 1'b1))); // R3
    AST_STOP_TO_VALID: assert property (@(posedge clk) disable iff (rst)
        (busy_o && stop_i) |=> result_valid_o); // R6
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        result_valid_o |=> !result_valid_o); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        overflow_o |-> (!result_valid_o && !busy_o)); // R7
    AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        fine_err_o |-> result_valid_o); // R9

endmodule

// File: tb/test_rdtdc_ctrl.sv
module test_rdtdc_ctrl;

    localparam int N     = 5;
    localparam int TAPS  = 8;
    localparam int FW    = 8;
    localparam int CYC_W = 4;
    localparam int RSW   = $clog2((2 ** CYC_W) * N * TAPS * FW);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic           stop = 1'b0;
    logic [7:0]     taps = '0;
    logic [7:0]     fine = '0;
    logic           inject, busy, result_valid, fine_err, overflow;
    logic [RSW-1:0] result;

    int n_chk = 0;
    int n_err = 0;
    int rnd_m = 0;
    bit prev_valid = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int    val;
        bit    err;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    rdtdc_ctrl #(.N(N), .TAPS(TAPS), .FW(FW), .CYC_W(CYC_W)) i_rdtdc_ctrl (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start),
        .stop_i         (stop),
        .taps_i         (taps),
        .fine_i         (fine),
        .inject_o       (inject),
        .busy_o         (busy),
        .result_valid_o (result_valid),
        .result_o       (result),
        .fine_err_o     (fine_err),
        .overflow_o     (overflow)
    );

    // reference round position, read at negedge = value sampled at next posedge
    always @(posedge clk) begin
        if (rst) rnd_m <= 0;
        else     rnd_m <= (rnd_m == N - 1) ? 0 : rnd_m + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int therm_ref(input logic [7:0] t);
        for (int i = 0; i < 8; i++) begin
            if (!t[i] && ((i == 7) || !t[i+1])) return i;
        end
        return 7;
    endfunction

    function automatic int fine_ref(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic bit ferr_ref(input logic [7:0] v);
        return $countones(v) != 1;
    endfunction

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (result_valid) begin
                if (prev_valid)
                    chk(1'b0, "R6 valid wider than one cycle", 1, 0);
                if (sb.size() == 0) begin
                    chk(1'b0, "R2 unexpected result", int'(result), -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(int'(result) == e.val, e.tag, int'(result), e.val);
                    chk(fine_err == e.err, {e.tag, " R9 fine_err"}, int'(fine_err), int'(e.err));
                end
            end else begin
                if (fine_err) chk(1'b0, "R9 fine_err without valid", 1, 0);
            end
        end
        prev_valid <= result_valid;
    end

    task automatic align(input int r);
        while (rnd_m != r) @(negedge clk);
    endtask

    // driver: one start/stop measurement, E = clock edges from start to stop
    task automatic meas(input int e_cnt, input logic [7:0] ts, input logic [7:0] fs,
                        input logic [7:0] te, input logic [7:0] fe,
                        input bit dbl, input string tag);
        int   s_rnd;
        exp_t x;
        start = 1'b1; taps = ts; fine = fs; s_rnd = rnd_m;
        @(negedge clk);
        start = 1'b0; taps = 8'hA5; fine = 8'hFF;
        chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
        chk(overflow == 1'b0, "R7 overflow cleared by start", int'(overflow), 0);
        for (int k = 1; k < e_cnt; k++) begin
            start = dbl && (k == 1);
            @(negedge clk);
        end
        start = 1'b0;
        stop = 1'b1; taps = te; fine = fe;
        x.val = (((s_rnd + e_cnt) * TAPS + therm_ref(te)) * FW + fine_ref(fe))
              - ((s_rnd * TAPS + therm_ref(ts)) * FW + fine_ref(fs));
        x.err = ferr_ref(fs) | ferr_ref(fe);
        x.tag = tag;
        sb.push_back(x);
        @(negedge clk);
        stop = 1'b0; taps = '0; fine = '0;
        @(negedge clk);
        chk(busy == 1'b0 && result_valid == 1'b0, "R6 strobe ends, back to armed",
            int'(busy) + int'(result_valid), 0);
    endtask

    initial begin
        int mism;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        chk(busy == 0 && result_valid == 0 && overflow == 0, "R8 reset state",
            int'(busy) + int'(result_valid) + int'(overflow), 0);

        // R1 inject select follows round counter
        mism = 0;
        for (int k = 0; k < 3 * N; k++) begin
            if (inject != (rnd_m == N - 1)) mism++;
            @(negedge clk);
        end
        chk(mism == 0, "R1 inject pattern", mism, 0);

        // R6 main function, several patterns
        align(1);
        meas(1, 8'b0000_0111, 8'b0000_0100, 8'b0001_1111, 8'b0100_0000, 1'b0, "R6 shortest interval");
        align(2);
        meas(7, 8'b0000_0001, 8'b0000_0001, 8'b0000_0011, 8'b0000_1000, 1'b0, "R6 across wraps");
        meas(33, 8'b0011_1111, 8'b1000_0000, 8'b0000_0000, 8'b0000_0010, 1'b0, "R6 long interval");
        // R3 start on the wrap cycle
        align(N - 1);
        meas(1, 8'b0000_0000, 8'b0000_0001, 8'b0000_0000, 8'b0000_0001, 1'b0, "R3 start at round N-1, E=1");
        align(N - 1);
        meas(12, 8'b0111_1111, 8'b0001_0000, 8'b0000_0111, 8'b0000_0001, 1'b0, "R3 start at round N-1, E=12");
        // R4 bubbles: 0-bubble at bit2, 1-bubble at bit5, all ones
        meas(4, 8'b0001_1011, 8'b0000_0001, 8'b0010_0011, 8'b0000_0001, 1'b0, "R4 thermometer bubbles");
        meas(3, 8'b1111_1111, 8'b0000_0001, 8'b1011_1111, 8'b0000_0001, 1'b0, "R4 all ones and top bubble");
        // R5 fine errors
        meas(5, 8'b0000_0011, 8'b0000_0000, 8'b0000_0011, 8'b0000_0100, 1'b0, "R5 empty fine vector");
        meas(5, 8'b0000_0011, 8'b0000_0010, 8'b0000_0011, 8'b0010_1000, 1'b0, "R5 multi-hot fine vector");
        // R2 second start while measuring ignored
        align(3);
        meas(6, 8'b0000_0001, 8'b0000_0010, 8'b0000_0111, 8'b0000_0001, 1'b1, "R2 extra start ignored");

        // R2 stop while armed ignored
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        chk(busy == 0 && result_valid == 0, "R2 stop in armed ignored",
            int'(busy) + int'(result_valid), 0);
        @(negedge clk);

        // R7 last representable position, stop in the same cycle as saturation
        align(0);
        meas((2 ** CYC_W) * N - 1, 8'b0000_0000, 8'b0000_0001, 8'b1111_1111, 8'b1000_0000, 1'b0,
             "R7 stop at last position");

        // R7 overflow
        align(0);
        start = 1'b1; taps = 8'h01; fine = 8'h01;
        @(negedge clk); start = 1'b0;
        repeat ((2 ** CYC_W) * N + 6) @(negedge clk);
        chk(overflow == 1'b1, "R7 overflow raised", int'(overflow), 1);
        chk(busy == 1'b0, "R7 busy dropped on overflow", int'(busy), 0);
        stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        @(negedge clk);
        chk(result_valid == 1'b0 && overflow == 1'b1, "R7 stop after overflow gives no result",
            int'(result_valid), 0);
        meas(2, 8'b0000_0001, 8'b0000_0001, 8'b0000_0011, 8'b0000_0001, 1'b0, "R7 recovery measurement");

        // R8 reset during a measurement
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 0 && result_valid == 0 && overflow == 0, "R8 reset aborts measurement",
            int'(busy) + int'(result_valid) + int'(overflow), 0);
        chk(inject == 1'b0, "R8 round counter cleared", int'(inject), 0);
        rst = 1'b0;
        @(negedge clk);
        meas(9, 8'b0000_1111, 8'b0000_1000, 8'b0000_0001, 8'b0000_0100, 1'b0, "R8 measurement after reset");

        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R6 all expected results seen", sb.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule